// File: doc/BRIEF.md
# Serial Flash Command Engine

This block is the device side of a serial configuration memory that is reached over an SPI-style link. It watches an active-low select, a serial clock and a data input, all sampled in the system clock domain. From these it assembles an 8-bit command and any address and data bytes that follow it, then acts on a small byte array held inside the block. Results go back on a single data output.

The command set covers data reads, status reads, an identity read, setting and clearing the write-enable latch, status writes, single-byte programming, sector erase and full-array erase. A parameterized countdown stands in for the time a program or erase cycle takes. While that countdown runs, the block turns away every command except the status read. Commands that change state are only carried out when select is released on a whole byte boundary after enough bytes. Any other release discards them without a trace.

The serial clock must stay high for at least three system clocks and low for at least three. Select must stay stable for at least two system clocks around each serial clock edge.

Top module: `sfc_cmd_engine`

## Requirements
- R1: Input bits are captured most significant bit first on the rising serial clock edges while select is low. Output bits change only after a falling serial clock edge, most significant bit first. The first output bit is valid before the first rising edge that follows the last input bit.
- R2: Command 0x03 followed by three address bytes returns array bytes starting at that address. Only the low ADDR_W address bits are used. The address steps up by one for each byte and wraps from the top of the array to 0.
- R3: Command 0x05 returns the status byte for as long as select stays low. Bit 0 is the busy flag, bit 1 is the write-enable latch and bits 7:2 are the user field. The value is live, including during a busy cycle.
- R4: Command 0xAB followed by three dummy bytes returns the DEV_ID byte, repeated for as long as select stays low.
- R5: Command 0x06 sets the write-enable latch and command 0x04 clears it.
- R6: Commands 0x06, 0x04, 0x01, 0x02, 0xD8 and 0xC7 take effect only when select rises after a whole number of bytes. The minimum byte counts are 1, 1, 2, 5, 4 and 1 respectively. Any other ending leaves the array, the status byte and the latch unchanged.
- R7: Commands 0x01, 0x02, 0xD8 and 0xC7 are refused while the write-enable latch is clear. Acceptance clears the latch.
- R8: Command 0x02, given an address and a data byte, stores the old array byte AND the data byte. Only the first data byte is used.
- R9: Command 0xD8 with an address sets every byte of the sector that holds that address to 0xFF. The top SECT_W address bits select the sector, and other sectors keep their contents. Command 0xC7 sets the whole array to 0xFF.
- R10: An accepted program, erase or status write holds the busy flag for BUSY_CYC system clocks. While busy, every command other than 0x05 is ignored. A data or identity read that begins while busy returns zero bytes.
- R11: An unrecognised command byte is ignored. The output stays 0 and no state changes.
- R12: Command 0x01 followed by a data byte writes data bits 7:2 into the status user field. Data bits 1:0 are discarded.
- R13: After reset the status byte is 0x00, every array byte is 0xFF and the output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select |
| sck | input | 1 | Serial clock, sampled by clk |
| mosi | input | 1 | Serial data into the block |
| miso | output | 1 | Serial data out of the block |

## Verification
A wrong bit or byte counter shows up in one of two ways. Commands released on a byte boundary get refused, or commands ending mid-byte get carried out. Either way, the next status read shows a wrong latch bit or the next data read shows altered bytes. A faulty busy countdown or latch shows in the very next status read, which is live. A faulty address path shows in the first read-back byte after a program or erase. Wrap and sector-boundary faults need the read to start at the array's top byte or to span a sector edge.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  localparam logic [7:0] OP_WREN   = 8'h06;
  localparam logic [7:0] OP_WRDI   = 8'h04;
  localparam logic [7:0] OP_RDSR   = 8'h05;
  localparam logic [7:0] OP_WRSR   = 8'h01;
  localparam logic [7:0] OP_READ   = 8'h03;
  localparam logic [7:0] OP_PROG   = 8'h02;
  localparam logic [7:0] OP_SERASE = 8'hD8;
  localparam logic [7:0] OP_BERASE = 8'hC7;
  localparam logic [7:0] OP_RDID   = 8'hAB;

  typedef enum logic [1:0] {
    SRC_NONE,
    SRC_STAT,
    SRC_MEM,
    SRC_ID
  } out_src_e;
endpackage

// File: rtl/sfc_serial_rx.sv
module sfc_serial_rx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sck,
  input  logic       mosi,
  output logic       sck_fall,
  output logic       cs_end,
  output logic       byte_vld,
  output logic [7:0] byte_dat,
  output logic [2:0] byte_idx,
  output logic [2:0] bit_pos,
  output logic [2:0] byte_cnt
);
  logic       cs_q, sck_q;
  logic [6:0] sh_q, sh_n;
  logic [2:0] bit_n, cnt_n, idx_n;
  logic       vld_n;
  logic [7:0] dat_n;
  logic       rise, cs_fall;

  assign rise     = ~cs_n & sck & ~sck_q;
  assign sck_fall = ~cs_n & ~sck & sck_q;
  assign cs_fall  = ~cs_n & cs_q;
  assign cs_end   = cs_n & ~cs_q;

  always_comb begin
    sh_n  = sh_q;
    bit_n = bit_pos;
    cnt_n = byte_cnt;
    vld_n = 1'b0;
    dat_n = byte_dat;
    idx_n = byte_idx;
    if (cs_fall) begin
      bit_n = 3'd0;
      cnt_n = 3'd0;
    end else if (rise) begin
      sh_n  = {sh_q[5:0], mosi};
      bit_n = bit_pos + 3'd1;
      if (bit_pos == 3'd7) begin
        vld_n = 1'b1;
        dat_n = {sh_q, mosi};
        idx_n = byte_cnt;
        if (byte_cnt != 3'd7) cnt_n = byte_cnt + 3'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q     <= 1'b1;
      sck_q    <= 1'b0;
      sh_q     <= '0;
      bit_pos  <= '0;
      byte_cnt <= '0;
      byte_vld <= 1'b0;
      byte_dat <= '0;
      byte_idx <= '0;
    end else begin
      cs_q     <= cs_n;
      sck_q    <= sck;
      sh_q     <= sh_n;
      bit_pos  <= bit_n;
      byte_cnt <= cnt_n;
      byte_vld <= vld_n;
      byte_dat <= dat_n;
      byte_idx <= idx_n;
    end
  end
endmodule

// File: rtl/sfc_busy_timer.sv
module sfc_busy_timer #(
  parameter int BUSY_CYC = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic wip
);
  localparam int CW = $clog2(BUSY_CYC + 1);
  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (start)              cnt_n = CW'(BUSY_CYC);
    else if (cnt_q != '0)   cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign wip = (cnt_q != '0);
endmodule

// File: rtl/sfc_byte_array.sv
module sfc_byte_array #(
  parameter int ADDR_W = 8,
  parameter int SECT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_en,
  input  logic [ADDR_W-1:0] prog_addr,
  input  logic [7:0]        prog_data,
  input  logic              sect_en,
  input  logic [SECT_W-1:0] sect_idx,
  input  logic              bulk_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int SECT_SH = ADDR_W - SECT_W;

  logic [7:0] cells [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    localparam logic [SECT_W-1:0] MY_SECT = SECT_W'(g >> SECT_SH);
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(g);
    logic       clr, en;
    logic [7:0] nxt;

    always_comb begin
      clr = bulk_en | (sect_en & (sect_idx == MY_SECT));
      en  = clr | (prog_en & (prog_addr == MY_ADDR));
      nxt = clr ? 8'hFF : (cells[g] & prog_data);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  cells[g] <= 8'hFF;
      else if (en) cells[g] <= nxt;
    end
  end

  assign rd_data = cells[rd_addr];
endmodule

// File: rtl/sfc_cmd_engine.sv
module sfc_cmd_engine
  import sfc_pkg::*;
#(
  parameter int         ADDR_W   = 8,
  parameter int         SECT_W   = 2,
  parameter int         BUSY_CYC = 64,
  parameter logic [7:0] DEV_ID   = 8'h2C
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic mosi,
  output logic miso
);
  logic       rst_s1, rst_sync;
  logic       sck_fall, cs_end, byte_vld;
  logic [7:0] byte_dat;
  logic [2:0] byte_idx, bit_pos, byte_cnt;
  logic       wip, busy_start;

  logic [7:0]        op_q, op_n, out_q, out_n, wdat_q, wdat_n, rd_data;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic              ok_q, ok_n, wel_q, wel_n, pend_q, pend_n, oen_q, oen_n;
  logic [5:0]        usr_q, usr_n;
  out_src_e          src_q, src_n;

  logic [7:0] op_now, status, load_val;
  logic       ok_now, aligned, go;
  logic       wren_go, wrdi_go, prog_go, sect_go, bulk_go, wrsr_go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1   <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_s1   <= 1'b1;
      rst_sync <= rst_s1;
    end
  end

  sfc_serial_rx u_rx (
    .clk(clk), .rst_n(rst_sync), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .sck_fall(sck_fall), .cs_end(cs_end), .byte_vld(byte_vld),
    .byte_dat(byte_dat), .byte_idx(byte_idx), .bit_pos(bit_pos),
    .byte_cnt(byte_cnt)
  );

  sfc_busy_timer #(.BUSY_CYC(BUSY_CYC)) u_busy (
    .clk(clk), .rst_n(rst_sync), .start(busy_start), .wip(wip)
  );

  sfc_byte_array #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_array (
    .clk(clk), .rst_n(rst_sync),
    .prog_en(prog_go), .prog_addr(addr_q), .prog_data(wdat_q),
    .sect_en(sect_go), .sect_idx(addr_q[ADDR_W-1 -: SECT_W]),
    .bulk_en(bulk_go), .rd_addr(addr_q), .rd_data(rd_data)
  );

  assign status = {usr_q, wel_q, wip};
  assign op_now = (byte_idx == 3'd0) ? byte_dat : op_q;
  assign ok_now = (byte_idx == 3'd0) ? ~wip : ok_q;

  always_comb begin
    case (src_q)
      SRC_STAT: load_val = status;
      SRC_MEM:  load_val = rd_data;
      SRC_ID:   load_val = DEV_ID;
      default:  load_val = 8'h00;
    endcase
  end

  // command acceptance at select release
  assign aligned    = (bit_pos == 3'd0) && (byte_cnt != 3'd0);
  assign go         = cs_end & aligned & ~wip;
  assign wren_go    = go & (op_q == OP_WREN);
  assign wrdi_go    = go & (op_q == OP_WRDI);
  assign prog_go    = go & wel_q & (op_q == OP_PROG)   & (byte_cnt >= 3'd5);
  assign sect_go    = go & wel_q & (op_q == OP_SERASE) & (byte_cnt >= 3'd4);
  assign bulk_go    = go & wel_q & (op_q == OP_BERASE);
  assign wrsr_go    = go & wel_q & (op_q == OP_WRSR)   & (byte_cnt >= 3'd2);
  assign busy_start = prog_go | sect_go | bulk_go | wrsr_go;

  always_comb begin
    op_n   = op_q;
    ok_n   = ok_q;
    addr_n = addr_q;
    wdat_n = wdat_q;
    pend_n = pend_q;
    src_n  = src_q;
    out_n  = out_q;
    oen_n  = oen_q;
    wel_n  = wel_q;
    usr_n  = usr_q;

    if (byte_vld) begin
      if (byte_idx == 3'd0) begin
        op_n = byte_dat;
        ok_n = ~wip;
      end
      if (byte_idx >= 3'd1 && byte_idx <= 3'd3)
        addr_n = ADDR_W'({addr_q, byte_dat});
      if ((byte_idx == 3'd1 && op_now == OP_WRSR) ||
          (byte_idx == 3'd4 && op_now == OP_PROG))
        wdat_n = byte_dat;
      if (op_now == OP_RDSR) begin
        pend_n = 1'b1;
        src_n  = SRC_STAT;
      end else if (byte_idx >= 3'd3 && ok_now && op_now == OP_READ) begin
        pend_n = 1'b1;
        src_n  = SRC_MEM;
      end else if (byte_idx >= 3'd3 && ok_now && op_now == OP_RDID) begin
        pend_n = 1'b1;
        src_n  = SRC_ID;
      end
    end

    if (sck_fall) begin
      if (pend_q) begin
        out_n  = load_val;
        oen_n  = 1'b1;
        pend_n = 1'b0;
        if (src_q == SRC_MEM) addr_n = addr_q + 1'b1;
      end else begin
        out_n = {out_q[6:0], 1'b0};
      end
    end

    if (cs_end) begin
      oen_n  = 1'b0;
      pend_n = 1'b0;
    end

    if (wren_go)               wel_n = 1'b1;
    if (wrdi_go || busy_start) wel_n = 1'b0;
    if (wrsr_go)               usr_n = wdat_q[7:2];
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      op_q   <= '0;
      ok_q   <= 1'b0;
      addr_q <= '0;
      wdat_q <= '0;
      pend_q <= 1'b0;
      src_q  <= SRC_NONE;
      out_q  <= '0;
      oen_q  <= 1'b0;
      wel_q  <= 1'b0;
      usr_q  <= '0;
    end else begin
      op_q   <= op_n;
      ok_q   <= ok_n;
      addr_q <= addr_n;
      wdat_q <= wdat_n;
      pend_q <= pend_n;
      src_q  <= src_n;
      out_q  <= out_n;
      oen_q  <= oen_n;
      wel_q  <= wel_n;
      usr_q  <= usr_n;
    end
  end

  assign miso = oen_q & out_q[7];
endmodule

// File: rtl/sfc_cmd_engine_chk.sv
module sfc_cmd_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       miso,
  input logic       sck_fall,
  input logic       start,
  input logic       wip,
  input logic       wel,
  input logic [2:0] bit_pos
);
  // R10: a new busy cycle never begins on top of a running one
  p_start_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !wip);

  // R7: the latch is already clear when the busy flag rises
  p_wel_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip) |-> !wel);

  // R6: acceptance only at select release on a byte boundary
  p_accept_aligned_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (cs_n && bit_pos == 3'd0));

  // R1: while selected, the output moves only after a falling serial edge
  p_miso_after_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(!cs_n) && !$stable(miso)) |-> $past(sck_fall));

  // R5: the latch can only be set while idle
  p_wel_set_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> !wip);
endmodule

bind sfc_cmd_engine sfc_cmd_engine_chk u_chk (
  .clk(clk), .rst_n(rst_sync), .cs_n(cs_n), .miso(miso),
  .sck_fall(sck_fall), .start(busy_start), .wip(wip), .wel(wel_q),
  .bit_pos(bit_pos)
);

// File: tb/sfc_cmd_engine_test.sv
module sfc_cmd_engine_test;
  localparam int         BUSY = 1000;
  localparam logic [7:0] ID   = 8'h2C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sck = 1'b0;
  logic mosi = 1'b0;
  logic miso;

  always #4 clk = ~clk;

  sfc_cmd_engine #(.ADDR_W(8), .SECT_W(2), .BUSY_CYC(BUSY), .DEV_ID(ID)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi), .miso(miso)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] tx [8];
  logic [7:0] rx [4];

  // {address, program data, expected read-back}
  localparam logic [23:0] VEC [7] = '{
    {8'h10, 8'h3C, 8'h3C},
    {8'h10, 8'hF0, 8'h30},
    {8'h11, 8'hA5, 8'hA5},
    {8'hFF, 8'h0F, 8'h0F},
    {8'h10, 8'hFF, 8'h30},
    {8'h40, 8'h00, 8'h00},
    {8'h00, 8'h5A, 8'h5A}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic shift_bit(input logic b, output logic r);
    mosi = b;
    repeat (4) @(negedge clk);
    r = miso;
    sck = 1'b1;
    repeat (4) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic txn(input int nin, input int nout, input int xbits);
    logic r;
    @(negedge clk);
    cs_n = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < nin; i++)
      for (int j = 7; j >= 0; j--) shift_bit(tx[i][j], r);
    for (int i = 0; i < nout; i++)
      for (int j = 7; j >= 0; j--) begin
        shift_bit(1'b0, r);
        rx[i][j] = r;
      end
    for (int k = 0; k < xbits; k++) shift_bit(1'b1, r);
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic cmd1(input logic [7:0] op);
    tx[0] = op;
    txn(1, 0, 0);
  endtask

  task automatic rdsr(output logic [7:0] s);
    tx[0] = 8'h05;
    txn(1, 1, 0);
    s = rx[0];
  endtask

  task automatic rd(input logic [7:0] a, input int n);
    tx[0] = 8'h03; tx[1] = 8'h00; tx[2] = 8'h00; tx[3] = a;
    txn(4, n, 0);
  endtask

  task automatic prog(input logic [7:0] a, input logic [7:0] d, input int xbits);
    tx[0] = 8'h02; tx[1] = 8'h00; tx[2] = 8'h00; tx[3] = a; tx[4] = d;
    txn(5, 0, xbits);
  endtask

  task automatic wait_busy();
    repeat (BUSY + 30) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R13: reset state
    chk("R13 miso", {7'd0, miso}, 8'h00);
    rdsr(s);
    chk("R13 status", s, 8'h00);
    rd(8'h00, 1);
    chk("R13 array", rx[0], 8'hFF);

    // R8: table of program then read-back
    foreach (VEC[v]) begin
      cmd1(8'h06);
      prog(VEC[v][23:16], VEC[v][15:8], 0);
      wait_busy();
      rd(VEC[v][23:16], 1);
      chk("R8 program AND", rx[0], VEC[v][7:0]);
    end

    // R1/R2: multi-byte read with increment, then wrap at the top
    rd(8'h10, 3);
    chk("R2 byte0", rx[0], 8'h30);
    chk("R2 byte1", rx[1], 8'hA5);
    chk("R1 byte2", rx[2], 8'hFF);
    rd(8'hFF, 2);
    chk("R2 top", rx[0], 8'h0F);
    chk("R2 wrap", rx[1], 8'h5A);

    // R5: latch set and clear
    cmd1(8'h06);
    rdsr(s);
    chk("R5 set", s, 8'h02);
    cmd1(8'h04);
    rdsr(s);
    chk("R5 clear", s, 8'h00);

    // R7: program without the latch is refused
    prog(8'h11, 8'h00, 0);
    wait_busy();
    rd(8'h11, 1);
    chk("R7 no latch", rx[0], 8'hA5);

    // R6: misaligned and short sequences are dropped
    cmd1(8'h06);
    prog(8'h11, 8'h00, 3);
    rdsr(s);
    chk("R6 misaligned keeps latch", s, 8'h02);
    rd(8'h11, 1);
    chk("R6 misaligned no write", rx[0], 8'hA5);
    tx[0] = 8'h02; tx[1] = 8'h00; tx[2] = 8'h00; tx[3] = 8'h11;
    txn(4, 0, 0);
    rdsr(s);
    chk("R6 short keeps latch", s, 8'h02);
    cmd1(8'h04);
    tx[0] = 8'h06;
    txn(1, 0, 3);
    rdsr(s);
    chk("R6 misaligned enable", s, 8'h00);

    // R3/R10: live status during busy, refused commands
    cmd1(8'h06);
    prog(8'h20, 8'h81, 0);
    tx[0] = 8'h05;
    txn(1, 2, 0);
    chk("R3 busy status a", rx[0], 8'h01);
    chk("R3 busy status b", rx[1], 8'h01);
    rd(8'h10, 1);
    chk("R10 read refused", rx[0], 8'h00);
    cmd1(8'h06);
    wait_busy();
    rdsr(s);
    chk("R10 enable ignored", s, 8'h00);
    rd(8'h20, 1);
    chk("R8 after busy", rx[0], 8'h81);

    // R9: sector erase then bulk erase
    cmd1(8'h06);
    tx[0] = 8'hD8; tx[1] = 8'h00; tx[2] = 8'h00; tx[3] = 8'h45;
    txn(4, 0, 0);
    wait_busy();
    rd(8'h40, 1);
    chk("R9 sector cleared", rx[0], 8'hFF);
    rd(8'h10, 1);
    chk("R9 other sector kept", rx[0], 8'h30);
    cmd1(8'h06);
    cmd1(8'hC7);
    wait_busy();
    rd(8'h10, 1);
    chk("R9 bulk", rx[0], 8'hFF);
    rd(8'hFF, 1);
    chk("R9 bulk top", rx[0], 8'hFF);

    // R11: unknown opcode
    tx[0] = 8'h5A;
    txn(1, 2, 0);
    chk("R11 out a", rx[0], 8'h00);
    chk("R11 out b", rx[1], 8'h00);
    rdsr(s);
    chk("R11 status", s, 8'h00);

    // R4: identity read
    tx[0] = 8'hAB; tx[1] = 8'h00; tx[2] = 8'h00; tx[3] = 8'h00;
    txn(4, 2, 0);
    chk("R4 id a", rx[0], ID);
    chk("R4 id b", rx[1], ID);

    // R12: status write keeps bits 7:2
    cmd1(8'h06);
    tx[0] = 8'h01; tx[1] = 8'hA9;
    txn(2, 0, 0);
    wait_busy();
    rdsr(s);
    chk("R12 user field", s, 8'hA8);

    finish_run();
  end
endmodule